// File: doc/BRIEF.md
# Byte-Lane Store Path Unit

This block forms the store side of a 16-bit, byte-addressable memory port. When its load strobe is high, it takes a source value from the processor bus and a one-bit access-size control. It formats the value and captures it in a memory data register. In a later cycle its write strobe is raised. The write-enable logic then drives one enable for each byte lane, chosen from the access size and the lowest address bit. A small word-wide memory with one write enable per byte lane takes the data register's lanes, so the stored result can be read back.

Formatting and lane selection are kept fully apart. A byte store always places the low source byte in both halves of the data register, whatever the address. Only the write-enable logic looks at address bit 0 to decide which half reaches memory. A word store passes the source value through unchanged and writes both lanes together. Word addresses are assumed to be even.

Top module: `stp_store_path`

## Requirements
- R1: When `mdr_load` is high and `size_word` is 1 (word), `mdr_q` equals the sampled `bus_data` in the following cycle.
- R2: When `mdr_load` is high and `size_word` is 0 (byte), `mdr_q` becomes {`bus_data[7:0]`, `bus_data[7:0]`} in the following cycle, whatever the value of `mar_addr[0]`.
- R3: While `mdr_load` is low, `mdr_q` keeps its value, whatever `bus_data`, `size_word` and `mar_addr` do.
- R4: While `mem_write` is high with `size_word` = 0, exactly one bit of `lane_we` is high: `lane_we` = 2'b01 (bit 0 = bits 7:0) when `mar_addr[0]` = 0, and 2'b10 (bit 1 = bits 15:8) when `mar_addr[0]` = 1.
- R5: While `mem_write` is high with `size_word` = 1, `lane_we` = 2'b11.
- R6: While `mem_write` is low, `lane_we` = 2'b00.
- R7: At a clock edge, each memory lane at word index `mar_addr[6:1]` takes the matching lane of `mdr_q` if its `lane_we` bit is high, and otherwise keeps its value. `rd_data` returns the word at index `rd_addr[6:1]` combinationally.
- R8: A synchronous active-high `rst` clears `mdr_q` and every memory word to zero.
- R9: If `mdr_load` and `mem_write` are high in the same cycle, memory receives the `mdr_q` value from before that edge, and `mdr_q` takes the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mdr_load | input | 1 | Load strobe for the memory data register |
| mem_write | input | 1 | Memory-write strobe qualifying the lane enables |
| size_word | input | 1 | Access size: 1 = word, 0 = byte |
| bus_data | input | 16 | Source register value from the bus |
| mar_addr | input | 16 | Byte address of the store |
| rd_addr | input | 16 | Byte address of the readback port |
| mdr_q | output | 16 | Memory data register contents |
| lane_we | output | 2 | Per-lane write enables (bit 0 = low byte) |
| rd_data | output | 16 | Readback word from the memory |

## Verification
Loading the data register and writing memory can happen in the same cycle. The write must then use the register's old contents while the register takes the new one. The bench provokes this by raising both strobes together after a known value has been loaded. It does this in directed steps and also in a long pseudo-random phase where the strobes are drawn independently. A behavioural model updates memory from its previous register value before it updates the register. The bench compares the readback word and the register with this model after every edge.

// File: rtl/stp_pkg.sv
package stp_pkg;
    localparam int DATA_W = 16;
    localparam int LANE_W = 8;
    localparam int LANES  = DATA_W / LANE_W;

    typedef enum logic {
        SZ_BYTE = 1'b0,
        SZ_WORD = 1'b1
    } size_e;

    typedef struct packed {
        logic        load;
        size_e       size;
        logic [DATA_W-1:0] src;
    } fmt_req_t;

    // Store formatting: word passes through, byte is replicated to all lanes.
    function automatic logic [DATA_W-1:0] format_store(size_e sz, logic [DATA_W-1:0] src);
        logic [DATA_W-1:0] rep;
        for (int l = 0; l < LANES; l++) rep[l*LANE_W +: LANE_W] = src[LANE_W-1:0];
        return (sz == SZ_WORD) ? src : rep;
    endfunction

    // Lane enables for a two-lane word: byte picks one lane by address bit 0.
    function automatic logic [LANES-1:0] lane_select(size_e sz, logic a0);
        logic [LANES-1:0] sel;
        if (sz == SZ_WORD) sel = '1;
        else begin
            sel = '0;
            sel[a0] = 1'b1;
        end
        return sel;
    endfunction
endpackage

// File: rtl/stp_fmt.sv
module stp_fmt
    import stp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  fmt_req_t          req,
    output logic [DATA_W-1:0] mdr_q
);
    always_ff @(posedge clk) begin
        if (rst) mdr_q <= '0;
        else if (req.load) mdr_q <= format_store(req.size, req.src);
    end

    p_word_load_r1: assert property (@(posedge clk) disable iff (rst)
        (req.load && req.size == SZ_WORD) |=> (mdr_q == $past(req.src)));

    p_byte_dup_r2: assert property (@(posedge clk) disable iff (rst)
        (req.load && req.size == SZ_BYTE) |=>
        (mdr_q[LANE_W-1:0] == $past(req.src[LANE_W-1:0]) &&
         mdr_q[DATA_W-1:LANE_W] == $past(req.src[LANE_W-1:0])));

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !req.load |=> $stable(mdr_q));

    p_reset_clear_r8: assert property (@(posedge clk)
        $past(rst) |-> (mdr_q == '0));
endmodule

// File: rtl/stp_we.sv
module stp_we
    import stp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  size_e            size,
    input  logic             a0,
    output logic [LANES-1:0] we
);
    always_comb we = wr ? lane_select(size, a0) : '0;

    p_byte_one_lane_r4: assert property (@(posedge clk) disable iff (rst)
        (wr && size == SZ_BYTE) |-> ($countones(we) == 1 && we[a0]));

    p_word_all_lanes_r5: assert property (@(posedge clk) disable iff (rst)
        (wr && size == SZ_WORD) |-> (we == '1));

    p_idle_no_we_r6: assert property (@(posedge clk) disable iff (rst)
        !wr |-> (we == '0));
endmodule

// File: rtl/stp_mem.sv
module stp_mem
    import stp_pkg::*;
#(
    parameter int WORDS  = 64,
    parameter int ADDR_W = 16,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LANES-1:0]  we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [IDX_W-1:0] widx, ridx;
    assign widx = waddr[IDX_W:1];
    assign ridx = raddr[IDX_W:1];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] cells [WORDS];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < WORDS; i++) cells[i] <= '0;
            end else if (we[l]) begin
                cells[widx] <= wdata[l*LANE_W +: LANE_W];
            end
        end

        assign rdata[l*LANE_W +: LANE_W] = cells[ridx];

        p_lane_write_r7: assert property (@(posedge clk) disable iff (rst)
            we[l] |=> (cells[$past(widx)] == $past(wdata[l*LANE_W +: LANE_W])));
    end
endmodule

// File: rtl/stp_store_path.sv
module stp_store_path
    import stp_pkg::*;
#(
    parameter int MEM_WORDS = 64,
    parameter int ADDR_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mdr_load,
    input  logic              mem_write,
    input  logic              size_word,
    input  logic [DATA_W-1:0] bus_data,
    input  logic [ADDR_W-1:0] mar_addr,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] mdr_q,
    output logic [LANES-1:0]  lane_we,
    output logic [DATA_W-1:0] rd_data
);
    size_e    size;
    fmt_req_t req;

    assign size = size_e'(size_word);
    assign req  = '{load: mdr_load, size: size, src: bus_data};

    stp_fmt u_fmt (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .mdr_q (mdr_q)
    );

    stp_we u_we (
        .clk  (clk),
        .rst  (rst),
        .wr   (mem_write),
        .size (size),
        .a0   (mar_addr[0]),
        .we   (lane_we)
    );

    stp_mem #(.WORDS(MEM_WORDS), .ADDR_W(ADDR_W)) u_mem (
        .clk   (clk),
        .rst   (rst),
        .we    (lane_we),
        .waddr (mar_addr),
        .wdata (mdr_q),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    // R9: a write alongside a load stores the register value from before the edge.
    p_old_mdr_written_r9: assert property (@(posedge clk) disable iff (rst)
        (mdr_load && mem_write && size == SZ_WORD && rd_addr[6:1] == mar_addr[6:1]) |=>
        (rd_data == $past(mdr_q) || !$stable(rd_addr)));
endmodule

// File: tb/tb_stp_store_path.sv
module tb_stp_store_path;
    localparam int CLK_PERIOD = 10;
    localparam int WORDS = 64;
    localparam int WATCHDOG = 20000;

    logic        clk = 1'b0;
    logic        rst, mdr_load, mem_write, size_word;
    logic [15:0] bus_data, mar_addr, rd_addr;
    logic [15:0] mdr_q, rd_data;
    logic [1:0]  lane_we;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [15:0] ref_mdr;
    logic [15:0] ref_mem [WORDS];

    always #(CLK_PERIOD/2) clk = ~clk;

    stp_store_path dut (
        .clk(clk), .rst(rst), .mdr_load(mdr_load), .mem_write(mem_write),
        .size_word(size_word), .bus_data(bus_data), .mar_addr(mar_addr),
        .rd_addr(rd_addr), .mdr_q(mdr_q), .lane_we(lane_we), .rd_data(rd_data)
    );

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] exp_we(logic wr, logic sw, logic a0);
        if (!wr) return 2'b00;
        if (sw) return 2'b11;
        return a0 ? 2'b10 : 2'b01;
    endfunction

    task automatic step(input logic ld, input logic wr, input logic sw,
                        input logic [15:0] bus, input logic [15:0] addr, input logic [15:0] ra);
        logic [1:0] we;
        string tag;
        @(negedge clk);
        mdr_load = ld; mem_write = wr; size_word = sw;
        bus_data = bus; mar_addr = addr; rd_addr = ra;
        #1;
        we = exp_we(wr, sw, addr[0]);
        tag = !wr ? "R6" : (sw ? "R5" : "R4");
        check(lane_we === we, tag, {14'd0, lane_we}, {14'd0, we});
        @(posedge clk);
        // model: memory takes the old register value, then the register loads
        if (we[0]) ref_mem[(addr >> 1) % WORDS][7:0]  = ref_mdr[7:0];
        if (we[1]) ref_mem[(addr >> 1) % WORDS][15:8] = ref_mdr[15:8];
        if (ld) ref_mdr = sw ? bus : {bus[7:0], bus[7:0]};
        #1;
        tag = !ld ? "R3" : (sw ? "R1" : "R2");
        check(mdr_q === ref_mdr, tag, mdr_q, ref_mdr);
        tag = (ld && wr) ? "R9" : "R7";
        check(rd_data === ref_mem[(ra >> 1) % WORDS], tag, rd_data, ref_mem[(ra >> 1) % WORDS]);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        rst = 1'b1; mdr_load = 0; mem_write = 0; size_word = 0;
        bus_data = 16'hFFFF; mar_addr = 0; rd_addr = 0;
        ref_mdr = 0;
        for (int i = 0; i < WORDS; i++) ref_mem[i] = 16'h0000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R8: reset state
        check(mdr_q === 16'h0000, "R8", mdr_q, 16'h0000);
        check(lane_we === 2'b00, "R8", {14'd0, lane_we}, 16'h0000);
        for (int a = 0; a < 8; a++) begin
            rd_addr = 16'(a * 18);
            #1;
            check(rd_data === 16'h0000, "R8", rd_data, 16'h0000);
        end

        // R1 word load, R5/R7 word write
        step(1, 0, 1, 16'hA5C3, 16'h0004, 16'h0004);
        step(0, 1, 1, 16'h0000, 16'h0004, 16'h0004);
        // R2 byte load at odd address, then R4 high-lane write
        step(1, 0, 0, 16'h127E, 16'h0005, 16'h0004);
        step(0, 1, 0, 16'h9999, 16'h0005, 16'h0004);
        // R2 byte load at even address, then R4 low-lane write
        step(1, 0, 0, 16'h3481, 16'h0004, 16'h0004);
        step(0, 1, 0, 16'h5555, 16'h0004, 16'h0004);
        // R3 hold with changing inputs, R6 no enables
        step(0, 0, 1, 16'hDEAD, 16'h0007, 16'h0006);
        step(0, 0, 0, 16'hBEEF, 16'h0006, 16'h0004);
        // R9 same-cycle load and write
        step(1, 0, 1, 16'h1357, 16'h0010, 16'h0010);
        step(1, 1, 1, 16'h2468, 16'h0010, 16'h0010);
        step(0, 1, 1, 16'h0000, 16'h0012, 16'h0012);
        step(1, 1, 0, 16'h00F0, 16'h0013, 16'h0012);
        // R7 top word index, both byte lanes separately
        step(1, 0, 0, 16'h00AB, 16'h007F, 16'h007E);
        step(0, 1, 0, 16'h0000, 16'h007F, 16'h007E);
        step(0, 1, 0, 16'h0000, 16'h007E, 16'h007E);

        // pseudo-random phase
        lfsr = 16'hACE1;
        for (int n = 0; n < 400; n++) begin
            logic [15:0] a;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            a = {9'd0, lfsr[6:0]};
            if (lfsr[9]) a[0] = 1'b0;
            step(lfsr[7], lfsr[8], lfsr[9], lfsr ^ 16'h5A3C, a, {9'd0, lfsr[15:10], 1'b0});
        end
        finish_run();
    end
endmodule